// File: doc/BRIEF.md
# Zoned read address sequencer

This block steps through a byte-wide user memory one byte at a time for a host that reads in order. The host pulses a start strobe with a start address and then asks for bytes through a valid/ready request channel. Each accepted request produces one byte on a valid/ready read channel in the cycle after acceptance. The block drives the array address itself and takes the array's combinational read data back. The address space is split into 16 equal zones. A per-zone permission vector decides whether the stored byte or a filler of all ones is returned.

At the last address the block does one of two things. In stop mode the address counter freezes, every further byte is filler, and a sticky error flag rises. In wrap mode the counter rolls over to address zero and reading carries on with no error. The permission vector comes from a configuration register outside the block, which resets to all ones (every zone readable).

Back-pressure rules: the read channel has a single output register. A byte stays on `rd_data` with `rd_valid` high until a cycle in which `rd_ready` is high. A new request is accepted only when that register is empty or is being drained in the same cycle, and never in a cycle where `start` is high.

Top module: `zoned_read_seq`

## Requirements
- R1: A cycle with `start` high loads `start_addr` into the address counter, so `mem_addr` equals it after that edge, and clears `err`.
- R2: A request accepted at a clock edge (`req_valid` and `req_ready` high) puts `rd_valid` high after that edge, with the byte for the current address. The counter then moves to the next address.
- R3: The zone of a byte is the top four bits of its address. Bit z of `zone_perm` set to 1 allows zone z. A 0 makes the block return 8'hFF in place of the stored byte, and the counter still advances.
- R4: With `wrap_en` 0, the byte at the last address is returned normally. The counter then stays at the last address, and every later request returns 8'hFF.
- R5: `err` rises with the first filler byte returned past the end. It stays high until the next `start`.
- R6: With `wrap_en` 1, the request after the last address reads address 0 and then continues upward, with no error.
- R7: While `rd_valid` is high and `rd_ready` is low, `rd_valid` and `rd_data` hold, `req_ready` is low and the counter does not move.
- R8: `start` takes precedence over a request: `req_ready` is low whenever `start` is high, so no byte comes from that cycle.
- R9: After reset `rd_valid` and `err` are 0 and `mem_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load start address, clear error |
| start_addr | input | ADDR_W | Start address |
| wrap_en | input | 1 | 1: roll over to 0 at end; 0: stop and flag |
| zone_perm | input | ZONES | Read permission per zone, 1 = allowed |
| req_valid | input | 1 | Next-byte request |
| req_ready | output | 1 | Request can be taken this cycle |
| mem_addr | output | ADDR_W | Array read address (current counter) |
| mem_rdata | input | DATA_W | Array read data for `mem_addr`, same cycle |
| rd_valid | output | 1 | Read byte valid |
| rd_ready | input | 1 | Host takes the read byte |
| rd_data | output | DATA_W | Read byte or filler |
| err | output | 1 | Sticky past-end error |

## Verification
Two collisions are provoked. First, a start strobe and a byte request are driven in the same cycle: the bench expects no byte from that cycle, the new address on `mem_addr`, and the stored byte of the new start address from the held request one cycle later. Second, a request is held while the read channel is stalled: the bench judges that the held byte and the address stay frozen, and that the request is taken in the very cycle `rd_ready` returns, giving the next byte.

// File: rtl/zrs_pkg.sv
package zrs_pkg;
  typedef enum logic {
    CTR_RUN  = 1'b0,
    CTR_DONE = 1'b1
  } ctr_state_e;
endpackage

// File: rtl/zrs_addr_ctr.sv
module zrs_addr_ctr #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              step,
  input  logic              wrap_en,
  output logic [ADDR_W-1:0] addr,
  output logic              past_end
);
  import zrs_pkg::*;
  localparam logic [ADDR_W-1:0] LAST = '1;

  ctr_state_e state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr    <= '0;
      state_q <= CTR_RUN;
    end else if (load) begin
      addr    <= load_addr;
      state_q <= CTR_RUN;
    end else if (step && state_q == CTR_RUN) begin
      if (addr == LAST) begin
        if (wrap_en) addr <= '0;
        else state_q <= CTR_DONE;
      end else begin
        addr <= addr + 1'b1;
      end
    end
  end

  assign past_end = (state_q == CTR_DONE);
endmodule

// File: rtl/zrs_zone_gate.sv
module zrs_zone_gate #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int ZONES  = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ZONES-1:0]  perm,
  input  logic              past_end,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] byte_out
);
  localparam int ZB = $clog2(ZONES);
  localparam logic [DATA_W-1:0] FILL = '1;

  logic [ZB-1:0] zone;
  logic          allowed;

  assign zone    = addr[ADDR_W-1 -: ZB];
  assign allowed = perm[zone];

  always_comb begin
    if (past_end || !allowed) byte_out = FILL;
    else byte_out = rdata;
  end
endmodule

// File: rtl/zrs_out_reg.sv
module zrs_out_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              can_take
);
  assign can_take = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/zoned_read_seq.sv
module zoned_read_seq #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int ZONES  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              wrap_en,
  input  logic [ZONES-1:0]  zone_perm,
  input  logic              req_valid,
  output logic              req_ready,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              err
);
  logic              accepted;
  logic              past_end;
  logic              slot_free;
  logic [DATA_W-1:0] gated;

  assign req_ready = !start && slot_free;
  assign accepted  = req_valid && req_ready;

  zrs_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(start), .load_addr(start_addr),
    .step(accepted), .wrap_en(wrap_en), .addr(mem_addr), .past_end(past_end)
  );

  zrs_zone_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ZONES(ZONES)) u_gate (
    .addr(mem_addr), .perm(zone_perm), .past_end(past_end),
    .rdata(mem_rdata), .byte_out(gated)
  );

  zrs_out_reg #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(accepted), .load_data(gated),
    .out_ready(rd_ready), .out_valid(rd_valid), .out_data(rd_data),
    .can_take(slot_free)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) err <= 1'b0;
    else if (start) err <= 1'b0;
    else if (accepted && past_end) err <= 1'b1;
  end
endmodule

// File: rtl/zrs_checker.sv
module zrs_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int ZONES  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              wrap_en,
  input logic [ZONES-1:0]  zone_perm,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [DATA_W-1:0] rd_data,
  input logic              err,
  input logic              past_end
);
  localparam int ZB = $clog2(ZONES);
  localparam logic [ADDR_W-1:0] LAST = '1;
  localparam logic [DATA_W-1:0] FILL = '1;

  logic take;
  assign take = req_valid && req_ready;

  p_valid_after_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> rd_valid);

  p_denied_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take && !zone_perm[mem_addr[ADDR_W-1 -: ZB]] |=> rd_data == FILL);

  p_counter_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    past_end && !start |=> $stable(mem_addr));

  p_beyond_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take && past_end |=> rd_data == FILL);

  p_err_on_beyond_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take && past_end |=> err);

  p_wrap_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take && wrap_en && !past_end && mem_addr == LAST |=> mem_addr == '0);

  p_hold_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

  p_start_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !req_ready);
endmodule

bind zoned_read_seq zrs_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ZONES(ZONES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .wrap_en(wrap_en),
  .zone_perm(zone_perm), .req_valid(req_valid), .req_ready(req_ready),
  .mem_addr(mem_addr), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_data(rd_data), .err(err), .past_end(past_end)
);

// File: tb/test_zoned_read_seq.sv
module test_zoned_read_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  start_addr = '0;
  logic        wrap_en = 1'b0;
  logic [15:0] zone_perm = 16'hFFFF;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  mem_addr;
  logic [7:0]  mem_rdata;
  logic        rd_valid;
  logic        rd_ready = 1'b1;
  logic [7:0]  rd_data;
  logic        err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  zoned_read_seq i_zoned_read_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .wrap_en(wrap_en), .zone_perm(zone_perm), .req_valid(req_valid),
    .req_ready(req_ready), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .err(err)
  );

  function automatic logic [7:0] mem_f(input logic [7:0] a);
    return {a[3:0], a[7:4]} ^ 8'h5A;
  endfunction

  always_comb mem_rdata = mem_f(mem_addr);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic        st;
    logic [7:0]  sa;
    logic [15:0] perm;
    logic        wrap;
    logic        fill;
    logic [7:0]  ea;
    logic        eerr;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h10, 16'hFFFF, 1'b0, 1'b0, 8'h10, 1'b0},  // R1 R2
    '{1'b0, 8'h00, 16'hFFFF, 1'b0, 1'b0, 8'h11, 1'b0},  // R2
    '{1'b1, 8'h2F, 16'hFFFB, 1'b0, 1'b1, 8'h00, 1'b0},  // R3 zone 2 denied
    '{1'b0, 8'h00, 16'hFFFB, 1'b0, 1'b0, 8'h30, 1'b0},  // R3 zone 3 open
    '{1'b1, 8'hFE, 16'hFFFF, 1'b0, 1'b0, 8'hFE, 1'b0},  // R4
    '{1'b0, 8'h00, 16'hFFFF, 1'b0, 1'b0, 8'hFF, 1'b0},  // R4 last byte
    '{1'b0, 8'h00, 16'hFFFF, 1'b0, 1'b1, 8'h00, 1'b1},  // R4 R5 beyond
    '{1'b0, 8'h00, 16'hFFFF, 1'b0, 1'b1, 8'h00, 1'b1},  // R4 R5 beyond
    '{1'b1, 8'hFF, 16'hFFFF, 1'b1, 1'b0, 8'hFF, 1'b0},  // R1 R6
    '{1'b0, 8'h00, 16'hFFFF, 1'b1, 1'b0, 8'h00, 1'b0},  // R6 wrap
    '{1'b0, 8'h00, 16'hFFFF, 1'b1, 1'b0, 8'h01, 1'b0},  // R6
    '{1'b1, 8'hF0, 16'h7FFF, 1'b0, 1'b1, 8'h00, 1'b0}   // R3 zone 15 denied
  };

  task automatic run_vec(input vec_t v, input int idx);
    logic [7:0] exp;
    @(negedge clk);
    zone_perm = v.perm;
    wrap_en = v.wrap;
    if (v.st) begin
      start = 1'b1;
      start_addr = v.sa;
      @(negedge clk);
      start = 1'b0;
    end
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    exp = v.fill ? 8'hFF : mem_f(v.ea);
    chk(rd_valid == 1'b1, $sformatf("R2 vec%0d valid", idx), rd_valid, 1);
    chk(rd_data == exp, $sformatf("R2/R3/R4/R6 vec%0d data", idx), rd_data, exp);
    chk(err == v.eerr, $sformatf("R5 vec%0d err", idx), err, v.eerr);
  endtask

  task automatic one_req();
    @(negedge clk);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    chk(rd_valid == 1'b0, "R9 rd_valid", rd_valid, 0);
    chk(err == 1'b0, "R9 err", err, 0);
    chk(mem_addr == 8'h00, "R9 mem_addr", mem_addr, 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R1 start loads address
    @(negedge clk);
    wrap_en = 1'b0; zone_perm = 16'hFFFF;
    start = 1'b1; start_addr = 8'h40;
    @(negedge clk);
    start = 1'b0;
    chk(mem_addr == 8'h40, "R1 load", mem_addr, 8'h40);

    // R7 back-pressure
    rd_ready = 1'b0;
    req_valid = 1'b1;
    @(negedge clk);
    chk(rd_valid && rd_data == mem_f(8'h40), "R7 first byte", rd_data, mem_f(8'h40));
    chk(req_ready == 1'b0, "R7 req_ready low", req_ready, 0);
    repeat (2) @(negedge clk);
    chk(rd_valid && rd_data == mem_f(8'h40), "R7 held byte", rd_data, mem_f(8'h40));
    chk(mem_addr == 8'h41, "R7 counter frozen", mem_addr, 8'h41);
    rd_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rd_valid && rd_data == mem_f(8'h41), "R7 drain and take", rd_data, mem_f(8'h41));
    chk(mem_addr == 8'h42, "R2 advance", mem_addr, 8'h42);
    @(negedge clk);

    // R8 start and request in the same cycle
    start = 1'b1; start_addr = 8'h80; req_valid = 1'b1;
    #1;
    chk(req_ready == 1'b0, "R8 req_ready under start", req_ready, 0);
    @(negedge clk);
    start = 1'b0;
    chk(rd_valid == 1'b0, "R8 no byte from start cycle", rd_valid, 0);
    chk(mem_addr == 8'h80, "R8 address loaded", mem_addr, 8'h80);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rd_valid && rd_data == mem_f(8'h80), "R8 held request served", rd_data, mem_f(8'h80));

    // R4 counter stops, R5 sticky error
    @(negedge clk);
    start = 1'b1; start_addr = 8'hFF;
    @(negedge clk);
    start = 1'b0;
    one_req();
    chk(err == 1'b0, "R5 no error on last byte", err, 0);
    for (int k = 0; k < 3; k++) begin
      one_req();
      chk(mem_addr == 8'hFF, "R4 counter stays at end", mem_addr, 8'hFF);
      chk(rd_data == 8'hFF, "R4 filler", rd_data, 8'hFF);
    end
    repeat (4) @(negedge clk);
    chk(err == 1'b1, "R5 error sticky", err, 1);
    start = 1'b1; start_addr = 8'h05;
    @(negedge clk);
    start = 1'b0;
    chk(err == 1'b0, "R1 start clears error", err, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule